// File: doc/BRIEF.md
# Horizontal Drive Source Switcher

This block produces the horizontal drive output of a display deflection stage. The output comes from one of two sources. The first is a line-rate pulse from the deflection PLL, which carries its own duty cycle. The second is a standby square wave. The standby wave is made by dividing a 5 MHz clock so that it runs at 50% duty, and with default settings it runs at 1 MHz. The PLL and the analog supply comparator sit outside this block. Here they appear only as a level input and a raw comparator bit.

Supervision decides which source drives the output:
- **Clock detector.** The output stays dark until the detector has seen the 5 MHz clock running. Once the clock is seen, the output always starts from the standby source.
- **Host coupling bit.** The block moves to the PLL source only while the host holds this bit set.
- **Power-down.** A filtered and stretched supply-low indication forces the standby source, exactly as clearing the coupling bit does.
- **Reset fallback.** This input also forces the standby source.

A source change never cuts a phase short. The block waits for the new source to make a transition into the level the output already holds, and only then hands over. The ongoing high or low phase can therefore grow by up to one source phase, but it is never shortened.

All inputs are sampled on a single fast reference clock. The filter, the stretch and the detector window are all counted in reference cycles.

Top module: `hdrv_switch`

## Requirements
- R1: After reset, and for as long as `clk_ok` is 0, `hout` and `hout_en` are both 0.
- R2: `clk_ok` changes only at the end of a window of WIN_CYC reference cycles. At that point it becomes 1 if at least MIN_EDGES rising edges of `clk5_in` were seen in the window, and 0 otherwise.
- R3: Once `clk_ok` is 1, the output first comes up on the standby source. `hout_en` rises while `hout` is 0, at a falling transition of the standby wave. After that, `hout` is high for HALF_EDGES transitions of `clk5_in` (either polarity) and low for the same number, which gives 50% duty.
- R4: `src_pll` (1 = PLL source drives `hout`) can become 1 only while `couple_pll` is 1, `pwr_down` is 0 and the fallback is inactive. While it is 1, `hout` follows `pll_hd_in`. Clearing `couple_pll` returns the output to the standby source.
- R5: `pwr_down` rises only after `supply_low_in` has been 1 for FILT_CYC+1 consecutive synchronized cycles. A shorter low pulse leaves `pwr_down` at 0 and leaves the source unchanged.
- R6: After `supply_low_in` returns to 0, `pwr_down` stays 1 for EXT_CYC more cycles and then falls.
- R7: A `pwr_down` of 1, or a `fallback_in` of 1, moves the output to the standby source with 50% duty, just as `couple_pll` = 0 does. When the condition clears, and `couple_pll` is still 1, the output returns to the PLL source.
- R8: A change between sources happens only in a cycle where the new source has just moved to the level `hout` already holds. `hout` does not toggle in that cycle, so no `hout` phase is shorter than the shortest phase of either source.
- R9: When `clk_ok` falls, `hout` and `hout_en` are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk5_in | input | 1 | 5 MHz clock, sampled as data |
| pll_hd_in | input | 1 | Line-rate drive level from the deflection PLL |
| couple_pll | input | 1 | Host bit: 1 requests the PLL source |
| supply_low_in | input | 1 | Raw digital-supply-low comparator output |
| fallback_in | input | 1 | Reset fallback: 1 forces the standby source |
| hout | output | 1 | Horizontal drive output |
| hout_en | output | 1 | 1 while a source drives `hout` |
| src_pll | output | 1 | 1 while the PLL source drives `hout` |
| clk_ok | output | 1 | 5 MHz clock detected |
| pwr_down | output | 1 | Filtered and stretched power-down |

## Verification
The bench drives the two sources with different waveforms. The standby wave has 125-cycle phases and the PLL pulse is 70 cycles high and 130 low. Because the phase lengths differ, measuring them shows which source is in control. The source selection is then moved through four conditions: coupling set, a long supply-low, reset fallback, and coupling cleared. A supply-low glitch shorter than the filter is compared with a long one, to separate filtering from reacting. The stretch is sampled on both sides of its end.

The clock is held absent at the start and removed again at the end. This separates the dark state from the standby state. The bench also watches every `hout` phase across all source changes and flags any phase shorter than the shortest source phase.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_STBY = 2'd1,
    SRC_PLL  = 2'd2
  } hd_src_e;
endpackage

// File: rtl/hdrv_sync.sv
module hdrv_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hdrv_clk_detect.sv
module hdrv_clk_detect #(
  parameter int WIN_CYC   = 256,
  parameter int MIN_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_s,
  output logic clk_ok
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic          prev_q;
  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          ok_q, ok_d;
  logic          rise, win_end;

  always_comb begin
    rise    = clk5_s & ~prev_q;
    win_end = (win_q == WW'(WIN_CYC - 1));
    cnt_inc = (rise && cnt_q != EW'(MIN_EDGES)) ? cnt_q + 1'b1 : cnt_q;
    win_d   = win_end ? '0 : win_q + 1'b1;
    cnt_d   = cnt_inc;
    ok_d    = ok_q;
    if (win_end) begin
      ok_d  = (cnt_inc == EW'(MIN_EDGES));
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      prev_q <= clk5_s;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      ok_q   <= ok_d;
    end
  end

  assign clk_ok = ok_q;

  AST_OK_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ok_q) |-> $past(win_end)) else $error("clk_ok moved mid-window"); // R2
endmodule

// File: rtl/hdrv_stby_div.sv
module hdrv_stby_div #(
  parameter int HALF_EDGES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_s,
  output logic stby_lvl
);
  localparam int CW = $clog2(HALF_EDGES + 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          edge_seen;

  always_comb begin
    edge_seen = clk5_s ^ prev_q;
    cnt_d     = cnt_q;
    lvl_d     = lvl_q;
    if (edge_seen) begin
      if (cnt_q == CW'(HALF_EDGES - 1)) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      prev_q <= clk5_s;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign stby_lvl = lvl_q;

  AST_STBY_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(edge_seen)) else $error("standby level moved without clock edge"); // R3
endmodule

// File: rtl/hdrv_pwr_sup.sv
module hdrv_pwr_sup #(
  parameter int FILT_CYC = 12,
  parameter int EXT_CYC  = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_s,
  output logic pwr_down
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int XW = $clog2(EXT_CYC + 1);

  logic [FW-1:0] fcnt_q, fcnt_d;
  logic [XW-1:0] xcnt_q, xcnt_d;
  logic          pd_q, pd_d;

  always_comb begin
    fcnt_d = '0;
    if (low_s) fcnt_d = (fcnt_q == FW'(FILT_CYC)) ? fcnt_q : fcnt_q + 1'b1;
    pd_d   = pd_q;
    if (low_s && fcnt_q == FW'(FILT_CYC)) pd_d = 1'b1;
    else if (!low_s && pd_q && xcnt_q == XW'(EXT_CYC - 1)) pd_d = 1'b0;
    xcnt_d = (!low_s && pd_q && pd_d) ? xcnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      xcnt_q <= '0;
      pd_q   <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      xcnt_q <= xcnt_d;
      pd_q   <= pd_d;
    end
  end

  assign pwr_down = pd_q;

  AST_PD_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(low_s)) else $error("power-down without supply low"); // R5
  AST_PD_FALL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(!low_s)) else $error("power-down dropped while supply low"); // R6
endmodule

// File: rtl/hdrv_switch.sv
module hdrv_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYC     = 256,
  parameter int MIN_EDGES   = 3,
  parameter int HALF_EDGES  = 5,
  parameter int FILT_CYC    = 12,
  parameter int EXT_CYC     = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_in,
  input  logic pll_hd_in,
  input  logic couple_pll,
  input  logic supply_low_in,
  input  logic fallback_in,
  output logic hout,
  output logic hout_en,
  output logic src_pll,
  output logic clk_ok,
  output logic pwr_down
);
  import hdrv_pkg::*;

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_out;
  logic clk5_s, pll_s, low_s, fb_s;
  logic stby_lvl;
  logic ok_w, pd_w;

  assign raw_in = {fallback_in, supply_low_in, pll_hd_in, clk5_in};
  assign {fb_s, low_s, pll_s, clk5_s} = syn_out;

  hdrv_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out));

  hdrv_clk_detect #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_det (
    .clk(clk), .rst_n(rst_n), .clk5_s(clk5_s), .clk_ok(ok_w));

  hdrv_stby_div #(.HALF_EDGES(HALF_EDGES)) u_div (
    .clk(clk), .rst_n(rst_n), .clk5_s(clk5_s), .stby_lvl(stby_lvl));

  hdrv_pwr_sup #(.FILT_CYC(FILT_CYC), .EXT_CYC(EXT_CYC)) u_sup (
    .clk(clk), .rst_n(rst_n), .low_s(low_s), .pwr_down(pd_w));

  hd_src_e cur_q, cur_d, want;
  logic    hout_q, hout_d;
  logic    stby_prev_q, pll_prev_q;
  logic    new_lvl, new_edge, cur_lvl;

  always_comb begin
    if (cur_q != SRC_NONE && couple_pll && !pd_w && !fb_s) want = SRC_PLL;
    else                                                    want = SRC_STBY;
    new_lvl  = (want == SRC_PLL) ? pll_s : stby_lvl;
    new_edge = (want == SRC_PLL) ? (pll_s ^ pll_prev_q) : (stby_lvl ^ stby_prev_q);
    case (cur_q)
      SRC_PLL:  cur_lvl = pll_s;
      SRC_STBY: cur_lvl = stby_lvl;
      default:  cur_lvl = 1'b0;
    endcase
    cur_d  = cur_q;
    hout_d = cur_lvl;
    if (!ok_w) begin
      cur_d  = SRC_NONE;
      hout_d = 1'b0;
    end else if (cur_q != want && new_edge && new_lvl == hout_q) begin
      cur_d  = want;
      hout_d = hout_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= SRC_NONE;
      hout_q      <= 1'b0;
      stby_prev_q <= 1'b0;
      pll_prev_q  <= 1'b0;
    end else begin
      cur_q       <= cur_d;
      hout_q      <= hout_d;
      stby_prev_q <= stby_lvl;
      pll_prev_q  <= pll_s;
    end
  end

  assign hout     = hout_q;
  assign hout_en  = (cur_q != SRC_NONE);
  assign src_pll  = (cur_q == SRC_PLL);
  assign clk_ok   = ok_w;
  assign pwr_down = pd_w;

  AST_DARK_WITHOUT_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_w |=> (!hout_q && cur_q == SRC_NONE)) else $error("output live without clock"); // R9
  AST_SWITCH_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) && (cur_q != SRC_NONE) |-> (hout_q == $past(hout_q)))
    else $error("hout toggled on source change"); // R8
  AST_PLL_NEEDS_COUPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == SRC_PLL) && ($past(cur_q) != SRC_PLL) |-> $past(couple_pll && !pd_w && !fb_s))
    else $error("PLL source taken without coupling"); // R4
  AST_FIRST_SOURCE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_q) == SRC_NONE) && (cur_q != SRC_NONE) |-> (cur_q == SRC_STBY && !hout_q))
    else $error("output did not start on standby low"); // R3
endmodule

// File: tb/hdrv_switch_tb.sv
`timescale 1ns/1ps
module hdrv_switch_tb;
  localparam int WIN   = 256;
  localparam int EXT   = 300;
  localparam int STBYP = 125;
  localparam int PLLH  = 70;
  localparam int PLLL  = 130;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk5 = 1'b0, clk5_run = 1'b0;
  logic pll = 1'b0;
  logic couple = 1'b0, sup_low = 1'b0, fb = 1'b0;
  logic hout, hout_en, src_pll, clk_ok, pwr_down;

  int tests = 0, fails = 0, cyc = 0;
  int c5_cnt = 0, pll_cnt = 0;
  int ph_len = 0, short_ph = 0;
  logic ph_valid = 1'b0, last_h = 1'b0;

  always #2 clk = ~clk;

  hdrv_switch #(.SYNC_STAGES(2), .WIN_CYC(WIN), .MIN_EDGES(3), .HALF_EDGES(5),
                .FILT_CYC(12), .EXT_CYC(EXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk5_in(clk5), .pll_hd_in(pll), .couple_pll(couple),
    .supply_low_in(sup_low), .fallback_in(fb), .hout(hout), .hout_en(hout_en),
    .src_pll(src_pll), .clk_ok(clk_ok), .pwr_down(pwr_down));

  always @(negedge clk) begin
    if (clk5_run) begin
      if (c5_cnt == 24) begin c5_cnt <= 0; clk5 <= ~clk5; end
      else c5_cnt <= c5_cnt + 1;
    end
    if (pll_cnt == (pll ? PLLH : PLLL) - 1) begin pll_cnt <= 0; pll <= ~pll; end
    else pll_cnt <= pll_cnt + 1;
  end

  // R8 phase monitor: no enabled phase shorter than the shortest source phase
  always @(negedge clk) begin
    if (rst_n && hout_en) begin
      if (hout == last_h) ph_len <= ph_len + 1;
      else begin
        if (ph_valid && ph_len < PLLH) short_ph <= short_ph + 1;
        ph_len   <= 1;
        ph_valid <= 1'b1;
      end
      last_h <= hout;
    end else begin
      ph_valid <= 1'b0;
      last_h   <= 1'b0;
      ph_len   <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (hout !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
    while (hout !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
    while (hout === 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    while (hout === 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    wait_cyc(3);
    chk(hout == 0 && hout_en == 0, "R1 reset output", {hout, hout_en}, 0);
    chk(clk_ok == 0 && pwr_down == 0 && src_pll == 0, "R1 reset status",
        {clk_ok, pwr_down, src_pll}, 0);
  endtask

  task automatic t_no_clock();
    wait_cyc(2 * WIN + 100);
    chk(clk_ok == 0, "R2 no clock no detect", clk_ok, 0);
    chk(hout == 0 && hout_en == 0, "R1 dark without clock", {hout, hout_en}, 0);
  endtask

  task automatic t_start_standby();
    int g = 0, hi, lo;
    clk5_run = 1'b1;
    while (!hout_en && g < 1200) begin @(negedge clk); g++; end
    chk(clk_ok == 1, "R2 clock detected", clk_ok, 1);
    chk(hout_en == 1 && hout == 0, "R3 enable on standby low", {hout_en, hout}, 2);
    chk(src_pll == 0, "R4 no PLL without coupling", src_pll, 0);
    measure(hi, lo);
    chk(hi == STBYP, "R3 standby high phase", hi, STBYP);
    chk(lo == STBYP, "R3 standby low phase", lo, STBYP);
  endtask

  task automatic t_couple();
    int hi, lo;
    couple = 1'b1;
    wait_cyc(600);
    chk(src_pll == 1, "R4 coupled to PLL", src_pll, 1);
    measure(hi, lo);
    chk(hi == PLLH && lo == PLLL, "R4 hout follows PLL", hi * 1000 + lo, PLLH * 1000 + PLLL);
  endtask

  task automatic t_supply_low();
    int rose = 0, hi, lo;
    sup_low = 1'b1;
    wait_cyc(6);
    sup_low = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwr_down) rose = 1; end
    chk(rose == 0, "R5 short glitch filtered", rose, 0);
    chk(src_pll == 1, "R5 glitch keeps PLL", src_pll, 1);
    sup_low = 1'b1;
    wait_cyc(30);
    chk(pwr_down == 1, "R5 long low raises power-down", pwr_down, 1);
    wait_cyc(500);
    chk(src_pll == 0, "R7 power-down forces standby", src_pll, 0);
    measure(hi, lo);
    chk(hi == STBYP && lo == STBYP, "R7 standby duty under power-down",
        hi * 1000 + lo, STBYP * 1000 + STBYP);
    sup_low = 1'b0;
    wait_cyc(EXT - 50);
    chk(pwr_down == 1, "R6 power-down stretched", pwr_down, 1);
    wait_cyc(80);
    chk(pwr_down == 0, "R6 power-down ends", pwr_down, 0);
    wait_cyc(600);
    chk(src_pll == 1, "R7 PLL restored after power-down", src_pll, 1);
  endtask

  task automatic t_fallback();
    int hi, lo;
    fb = 1'b1;
    wait_cyc(600);
    chk(src_pll == 0, "R7 fallback forces standby", src_pll, 0);
    measure(hi, lo);
    chk(hi == STBYP && lo == STBYP, "R7 standby duty under fallback",
        hi * 1000 + lo, STBYP * 1000 + STBYP);
    fb = 1'b0;
    wait_cyc(600);
    chk(src_pll == 1, "R7 PLL restored after fallback", src_pll, 1);
  endtask

  task automatic t_decouple();
    couple = 1'b0;
    wait_cyc(600);
    chk(src_pll == 0 && hout_en == 1, "R4 decouple returns to standby", {src_pll, hout_en}, 1);
  endtask

  task automatic t_clock_loss();
    chk(short_ph == 0, "R8 no shortened phase", short_ph, 0);
    clk5_run = 1'b0;
    wait_cyc(2 * WIN + 20);
    chk(clk_ok == 0, "R2 clock loss detected", clk_ok, 0);
    chk(hout == 0 && hout_en == 0, "R9 dark after clock loss", {hout, hout_en}, 0);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_no_clock();
    t_start_standby();
    t_couple();
    t_supply_low();
    t_fallback();
    t_decouple();
    t_clock_loss();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule